// File: doc/BRIEF.md
# Interleaved Memory Line Fetcher

This block refills one cache line at a time from a main memory built out of four interleaved word banks. A requester presents a line address with a valid/ready handshake. The fetcher then returns the four words of that line on a response channel, one word per cycle, in word order, and flags the final word. Word `w` of line `L` sits at word address `4*L + w`. The two low word-address bits pick the bank and the rest pick the row inside that bank, so every word of one line lives in a different bank.

In the default interleaved build, one address cycle starts all four banks together. After the shared bank access time, the four words stream out back to back. A parameter selects a one-word-at-a-time reference build instead. That build pays the address, access and transfer cost for each word in turn. Each finished refill publishes its own cycle count on a status output, so the two builds can be compared directly.

The bank models are synchronous arrays with a fixed access latency. A write port exists only so that a testbench can fill them with a known pattern.

Top module: `ilv_line_fetch`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0, `stat_valid` is 0 and `stat_cycles` is 0.
- R2: Word `w` (0..3) of line `L` is read from bank `w` at row `L`, which is the word that the fill port stored with `fill_bank = w` and `fill_row = L`.
- R3: A request is taken at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance through the cycle that carries the last word, and is 1 again in the following cycle.
- R4: In interleaved mode (`INTERLEAVE = 1`), counting the cycle after the acceptance edge as cycle 1, words 0, 1, 2 and 3 appear with `rsp_valid = 1` in cycles ACC_LAT+2 through ACC_LAT+5. With ACC_LAT = 4 that is cycles 6 to 9, with no gap between words.
- R5: In sequential mode (`INTERLEAVE = 0`), word `k` appears alone in cycle `(k+1)*(ACC_LAT+2)`, which is cycles 6, 12, 18 and 24 for ACC_LAT = 4. `rsp_valid` is 0 in every other cycle of the refill, and at most one bank is accessing at any time.
- R6: `rsp_last` is 1 exactly on the cycle carrying word 3 and 0 on words 0 to 2.
- R7: One cycle after the last word, `stat_valid` pulses for one cycle and `stat_cycles` equals the refill length. The length is `ACC_LAT + 5` when interleaved (9) and `4 * (ACC_LAT + 2)` when sequential (24). The value holds until the next refill completes.
- R8: `req_valid` and `req_line` are ignored while a refill is in progress. The line being returned does not change, and no extra refill starts from a request that is withdrawn before `req_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Line request present |
| req_line | input | ROW_W | Line address (row inside every bank) |
| req_ready | output | 1 | Fetcher idle and able to accept a request |
| rsp_valid | output | 1 | Response word present this cycle |
| rsp_data | output | DATA_W | Response word |
| rsp_last | output | 1 | Response word is the last of the line |
| stat_valid | output | 1 | One-cycle pulse: refill just completed |
| stat_cycles | output | STAT_W | Cycle count of the most recent refill |
| fill_en | input | 1 | Bench-only bank write strobe |
| fill_bank | input | 2 | Bench-only bank select for the write |
| fill_row | input | ROW_W | Bench-only row for the write |
| fill_data | input | DATA_W | Bench-only write data |

## Verification
The bench builds two copies side by side with DATA_W = 32, ROW_W = 6 and ACC_LAT = 4. Copy `uut` uses INTERLEAVE = 1 and copy `uut_seq` uses INTERLEAVE = 0, so the same stimulus exercises both the 9-cycle parallel refill and the 24-cycle word-by-word refill, and their timing can be compared. The six-bit row width is small enough to fill every bank with a computed pattern, which lets the bench reach the first and last rows and catch any mix-up of bank or row. Requests held high during a refill, with a different line address, test that busy-time input is ignored in both modes.

// File: rtl/ilf_pkg.sv
package ilf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_ACC  = 2'd2,
    ST_XFER = 2'd3
  } fsm_t;

  // Bank holding a given word address: low selector bits.
  function automatic int unsigned bank_of(input int unsigned waddr, input int unsigned sel_w);
    return waddr % (1 << sel_w);
  endfunction

  // Row inside a bank for a given word address.
  function automatic int unsigned row_of(input int unsigned waddr, input int unsigned sel_w);
    return waddr >> sel_w;
  endfunction

  // Cycles from acceptance edge to end of the last transfer cycle.
  function automatic int unsigned refill_cycles(input bit interleave,
                                                input int unsigned acc_lat,
                                                input int unsigned words);
    if (interleave) return 1 + acc_lat + words;
    return words * (2 + acc_lat);
  endfunction

endpackage

// File: rtl/ilf_bank.sv
module ilf_bank #(
  parameter int DATA_W  = 32,
  parameter int ROW_W   = 6,
  parameter int ACC_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  input  logic [ROW_W-1:0]  row,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ROW_W;
  localparam int CNT_W = $clog2(ACC_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACC_LAT);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ROW_W-1:0]  row_q;
  logic [CNT_W-1:0]  cnt_q;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_ONE);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      row_q <= '0;
    end else if (start) begin
      cnt_q <= CNT_LOAD;
      row_q <= row;
    end else if (busy) begin
      cnt_q <= cnt_q - CNT_ONE;
    end
  end

  // Result register: loaded when an access completes, held otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (done) rd_data <= mem[row_q];
  end

endmodule

// File: rtl/ilf_sched.sv
module ilf_sched
  import ilf_pkg::*;
#(
  parameter int  NBANK      = 4,
  parameter int  SEL_W      = 2,
  parameter int  ROW_W      = 6,
  parameter bit  INTERLEAVE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [ROW_W-1:0] req_line,
  output logic             req_ready,
  output logic             accept,
  input  logic [NBANK-1:0] bank_done,
  output logic [NBANK-1:0] bank_start,
  output logic [ROW_W-1:0] line_q,
  output logic [SEL_W-1:0] word_idx,
  output logic             xfer,
  output logic             xfer_last
);
  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NBANK - 1);

  fsm_t st_q, st_d;
  logic [NBANK-1:0] use_mask;
  logic all_done;

  generate
    if (INTERLEAVE) begin : g_par
      assign use_mask = '1;
    end else begin : g_seq
      assign use_mask = NBANK'(1) << word_idx;
    end
  endgenerate

  assign all_done   = &(bank_done | ~use_mask);
  assign req_ready  = (st_q == ST_IDLE);
  assign accept     = req_ready && req_valid;
  assign bank_start = (st_q == ST_ADDR) ? use_mask : '0;
  assign xfer       = (st_q == ST_XFER);
  assign xfer_last  = xfer && (word_idx == LAST_IDX);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) st_d = ST_ADDR;
      ST_ADDR: st_d = ST_ACC;
      ST_ACC:  if (all_done) st_d = ST_XFER;
      ST_XFER: begin
        if (word_idx == LAST_IDX) st_d = ST_IDLE;
        else if (!INTERLEAVE)     st_d = ST_ADDR;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      line_q   <= '0;
      word_idx <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        line_q   <= req_line;
        word_idx <= '0;
      end else if (xfer && !xfer_last) begin
        word_idx <= word_idx + SEL_W'(1);
      end
    end
  end

endmodule

// File: rtl/ilf_lat.sv
module ilf_lat #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              busy,
  input  logic              finish,
  output logic              stat_valid,
  output logic [STAT_W-1:0] stat_cycles
);
  localparam logic [STAT_W-1:0] CNT_MAX = '1;

  logic [STAT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      stat_valid  <= 1'b0;
      stat_cycles <= '0;
    end else begin
      stat_valid <= finish;
      if (finish) stat_cycles <= cnt_q;
      if (accept) cnt_q <= STAT_W'(1);
      else if (busy && cnt_q != CNT_MAX) cnt_q <= cnt_q + STAT_W'(1);
    end
  end

endmodule

// File: rtl/ilv_line_fetch.sv
module ilv_line_fetch
  import ilf_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ROW_W      = 6,
  parameter int ACC_LAT    = 4,
  parameter bit INTERLEAVE = 1'b1,
  parameter int STAT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ROW_W-1:0]  req_line,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last,
  output logic              stat_valid,
  output logic [STAT_W-1:0] stat_cycles,
  input  logic              fill_en,
  input  logic [1:0]        fill_bank,
  input  logic [ROW_W-1:0]  fill_row,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int NBANK = 4;
  localparam int SEL_W = $clog2(NBANK);

  logic              accept;
  logic [NBANK-1:0]  bank_done;
  logic [NBANK-1:0]  bank_busy;
  logic [NBANK-1:0]  bank_start;
  logic [ROW_W-1:0]  line_q;
  logic [SEL_W-1:0]  word_idx;
  logic              xfer_last;
  logic [DATA_W-1:0] bank_rd [NBANK];

  ilf_sched #(
    .NBANK(NBANK), .SEL_W(SEL_W), .ROW_W(ROW_W), .INTERLEAVE(INTERLEAVE)
  ) u_sched (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_line(req_line), .req_ready(req_ready),
    .accept(accept), .bank_done(bank_done), .bank_start(bank_start),
    .line_q(line_q), .word_idx(word_idx),
    .xfer(rsp_valid), .xfer_last(xfer_last)
  );

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      ilf_bank #(
        .DATA_W(DATA_W), .ROW_W(ROW_W), .ACC_LAT(ACC_LAT)
      ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(fill_en && (fill_bank == SEL_W'(b))),
        .wr_row(fill_row), .wr_data(fill_data),
        .start(bank_start[b]), .row(line_q),
        .busy(bank_busy[b]), .done(bank_done[b]),
        .rd_data(bank_rd[b])
      );
    end
  endgenerate

  assign rsp_data = bank_rd[word_idx];
  assign rsp_last = xfer_last;

  ilf_lat #(.STAT_W(STAT_W)) u_lat (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .busy(!req_ready), .finish(xfer_last),
    .stat_valid(stat_valid), .stat_cycles(stat_cycles)
  );

endmodule

// File: rtl/ilf_chk.sv
module ilf_chk
  import ilf_pkg::*;
#(
  parameter int ROW_W      = 6,
  parameter int ACC_LAT    = 4,
  parameter bit INTERLEAVE = 1'b1,
  parameter int STAT_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_last,
  input logic              stat_valid,
  input logic [STAT_W-1:0] stat_cycles,
  input logic              accept,
  input logic [ROW_W-1:0]  line_q,
  input logic [3:0]        bank_busy
);
  localparam logic [STAT_W-1:0] EXP_CYC = STAT_W'(refill_cycles(INTERLEAVE, ACC_LAT, 4));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (req_ready && !rsp_valid && !stat_valid) || !rst_n);

  // R3
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R3
  ready_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_last |=> req_ready);

  // R4
  burst_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    INTERLEAVE && rsp_valid && !rsp_last |=> rsp_valid);

  // R5
  seq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !INTERLEAVE && rsp_valid && !rsp_last |=> !rsp_valid);

  // R5
  seq_one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !INTERLEAVE |-> $onehot0(bank_busy));

  // R7
  stat_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_last |=> stat_valid && stat_cycles == EXP_CYC);

  // R7
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_valid && !$past(!rst_n) |-> $stable(stat_cycles));

  // R8
  busy_line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && req_valid |=> $stable(line_q));

endmodule

bind ilv_line_fetch ilf_chk #(
  .ROW_W(ROW_W), .ACC_LAT(ACC_LAT), .INTERLEAVE(INTERLEAVE), .STAT_W(STAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_last(rsp_last), .stat_valid(stat_valid),
  .stat_cycles(stat_cycles), .accept(accept), .line_q(line_q),
  .bank_busy(bank_busy)
);

// File: tb/ilv_line_fetch_test.sv
module ilv_line_fetch_test;
  localparam int DW = 32;
  localparam int RW = 6;
  localparam int AL = 4;
  localparam int SW = 8;
  localparam int LAT_PAR = AL + 5;
  localparam int LAT_SEQ = 4 * (AL + 2);

  typedef struct {
    int          cyc;
    logic [DW-1:0] d;
    logic        l;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic          rq_v [2];
  logic [RW-1:0] rq_l [2];
  logic          rdy  [2];
  logic          rv   [2];
  logic [DW-1:0] rd   [2];
  logic          rl   [2];
  logic          sv   [2];
  logic [SW-1:0] sc   [2];
  logic          f_en = 1'b0;
  logic [1:0]    f_bank = '0;
  logic [RW-1:0] f_row = '0;
  logic [DW-1:0] f_data = '0;

  ilv_line_fetch #(.DATA_W(DW), .ROW_W(RW), .ACC_LAT(AL), .INTERLEAVE(1'b1), .STAT_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(rq_v[0]), .req_line(rq_l[0]), .req_ready(rdy[0]),
    .rsp_valid(rv[0]), .rsp_data(rd[0]), .rsp_last(rl[0]),
    .stat_valid(sv[0]), .stat_cycles(sc[0]),
    .fill_en(f_en), .fill_bank(f_bank), .fill_row(f_row), .fill_data(f_data));

  ilv_line_fetch #(.DATA_W(DW), .ROW_W(RW), .ACC_LAT(AL), .INTERLEAVE(1'b0), .STAT_W(SW)) uut_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(rq_v[1]), .req_line(rq_l[1]), .req_ready(rdy[1]),
    .rsp_valid(rv[1]), .rsp_data(rd[1]), .rsp_last(rl[1]),
    .stat_valid(sv[1]), .stat_cycles(sc[1]),
    .fill_en(f_en), .fill_bank(f_bank), .fill_row(f_row), .fill_data(f_data));

  int n_vec = 0;
  int n_bad = 0;
  exp_t wq0[$];
  exp_t wq1[$];
  exp_t lq0[$];
  exp_t lq1[$];

  function automatic logic [DW-1:0] pat(input int bank, input int row);
    return (32'h1357_0000 * (bank + 1)) ^ (32'h0000_0b1d * (row + 3)) ^ 32'h8000_0001;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic mon_word(input int i);
    exp_t e;
    if ((i == 0 ? wq0.size() : wq1.size()) == 0) begin
      chk(1'b0, "R8", $sformatf("unexpected word inst%0d", i), longint'(rd[i]), 0);
    end else begin
      e = (i == 0) ? wq0.pop_front() : wq1.pop_front();
      chk(cyc == e.cyc, (i == 0) ? "R4" : "R5", $sformatf("word cycle inst%0d", i), cyc, e.cyc);
      chk(rd[i] == e.d, "R2", $sformatf("word data inst%0d", i), rd[i], e.d);
      chk(rl[i] == e.l, "R6", $sformatf("last flag inst%0d", i), rl[i], e.l);
    end
  endtask

  task automatic mon_stat(input int i);
    exp_t e;
    if ((i == 0 ? lq0.size() : lq1.size()) == 0) begin
      chk(1'b0, "R7", $sformatf("unexpected stat pulse inst%0d", i), 1, 0);
    end else begin
      e = (i == 0) ? lq0.pop_front() : lq1.pop_front();
      chk(cyc == e.cyc, "R7", $sformatf("stat cycle inst%0d", i), cyc, e.cyc);
      chk(sc[i] == e.d[SW-1:0], "R7", $sformatf("stat count inst%0d", i), sc[i], e.d);
    end
  endtask

  bit mon_on = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      for (int i = 0; i < 2; i++) begin
        if (rv[i]) mon_word(i);
        if (sv[i]) mon_stat(i);
      end
    end
  end

  // Driver: issue one line request; junk=1 keeps req_valid high with another line while busy.
  task automatic issue(input int i, input int line, input bit junk);
    int a;
    int lat;
    exp_t e;
    lat = (i == 0) ? LAT_PAR : LAT_SEQ;
    @(negedge clk);
    while (!rdy[i]) @(negedge clk);
    rq_v[i] = 1'b1;
    rq_l[i] = RW'(line);
    @(negedge clk);
    a = cyc;
    chk(rdy[i] == 1'b0, "R3", $sformatf("ready low after accept inst%0d", i), rdy[i], 0);
    for (int w = 0; w < 4; w++) begin
      e.cyc = (i == 0) ? a + AL + 1 + w : a + (w + 1) * (AL + 2) - 1;
      e.d   = pat(w, line);
      e.l   = (w == 3);
      if (i == 0) wq0.push_back(e); else wq1.push_back(e);
    end
    e.cyc = a + lat;
    e.d   = DW'(lat);
    e.l   = 1'b0;
    if (i == 0) lq0.push_back(e); else lq1.push_back(e);
    if (junk) begin
      rq_l[i] = RW'(line ^ 5);
      repeat (6) @(negedge clk);
    end
    rq_v[i] = 1'b0;
    while (cyc < a + lat - 1) @(negedge clk);
    chk(rdy[i] == 1'b0, "R3", $sformatf("ready low on last word inst%0d", i), rdy[i], 0);
    @(negedge clk);
    chk(rdy[i] == 1'b1, "R3", $sformatf("ready back inst%0d", i), rdy[i], 1);
  endtask

  initial begin
    rq_v[0] = 1'b0; rq_v[1] = 1'b0;
    rq_l[0] = '0;   rq_l[1] = '0;
    repeat (3) @(negedge clk);
    // R1: values during reset
    for (int i = 0; i < 2; i++) begin
      chk(rdy[i] == 1'b1, "R1", "ready in reset", rdy[i], 1);
      chk(rv[i] == 1'b0 && sv[i] == 1'b0, "R1", "valid in reset", {rv[i], sv[i]}, 0);
      chk(sc[i] == '0, "R1", "stat in reset", sc[i], 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(rdy[i] == 1'b1 && rv[i] == 1'b0, "R1", "idle after reset", {rdy[i], rv[i]}, 2);
    end
    for (int b = 0; b < 4; b++) begin
      for (int r = 0; r < (1 << RW); r++) begin
        f_en = 1'b1; f_bank = 2'(b); f_row = RW'(r); f_data = pat(b, r);
        @(negedge clk);
      end
    end
    f_en = 1'b0;
    mon_on = 1'b1;
    // R2 R4 R6 R7: interleaved refills over several rows
    issue(0, 0, 1'b0);
    issue(0, 63, 1'b0);
    issue(0, 17, 1'b0);
    // R8: busy-time requests ignored
    issue(0, 5, 1'b1);
    issue(0, 42, 1'b0);
    // R5 R7 R8: sequential reference build
    issue(1, 3, 1'b0);
    issue(1, 62, 1'b1);
    issue(1, 0, 1'b0);
    repeat (30) @(negedge clk);
    chk(wq0.size() == 0 && wq1.size() == 0, "R4", "words outstanding", wq0.size() + wq1.size(), 0);
    chk(lq0.size() == 0 && lq1.size() == 0, "R7", "stats outstanding", lq0.size() + lq1.size(), 0);
    chk(sc[0] == SW'(LAT_PAR), "R7", "stat held par", sc[0], LAT_PAR);
    chk(sc[1] == SW'(LAT_SEQ), "R7", "stat held seq", sc[1], LAT_SEQ);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule